// File: doc/BRIEF.md
# Submodule Gating Guard with Dead-Time and Minimum-Width Protection

This block sits between a multilevel modulator and the gate drivers of one converter arm built from `N_SM` switching submodules. Each submodule receives an ideal insert/bypass command every clock. The guard does two things to that command. It filters it, so that any new command value held for fewer cycles than a programmable minimum width never reaches the gates. It then opens a dead-time window after every accepted change. The window lasts a programmable number of cycles, and a new change restarts it.

While a submodule is inside its dead-time window, all of its switches are off. Its contribution to the arm voltage is then fixed by the direction of the arm current flowing through the antiparallel diodes, not by the command. A zero current sign marks the submodule as free-wheeling. The block runs in unipolar mode (insert positive or bypass) or in bipolar mode (insert positive, insert negative or bypass).

Every cycle the guard reports the state of each submodule. It also reports two arm-level figures: the signed net inserted level, and the number of free-wheeling submodules.

Top module: `sm_gate_guard`

## Requirements
- R1: While `rst` is sampled high, and after it, every submodule status is bypass (00), no submodule is in dead-time, `ins_level` is 0 and `free_count` is 0.
- R2: The command for submodule i is `cmd_in[2i+1:2i]`: 01 means insert positive, 11 means insert negative, and 00 and 10 mean bypass. When `bip_mode` is 0, code 11 is treated as bypass. The status for submodule i is `sm_status[2i+1:2i]`: 00 bypass, 01 inserted positive, 10 inserted negative, 11 free-wheeling.
- R3: A new command value is accepted only once it has been sampled on `min_cycles` consecutive clock edges, the current edge included. With `min_cycles` of 0 or 1 it is accepted on its first edge. A value that changes before then never appears. A change that is still pending when a new value arrives is not dropped: the count restarts for the new value.
- R4: Each change of a submodule's accepted state puts that submodule in dead-time for the next `dead_cycles` cycles. A `dead_cycles` value of 0 disables dead-time.
- R5: An accepted change that arrives during a running dead-time window reloads the window to the full `dead_cycles` length.
- R6: During dead-time, a current sign of 01 (positive) gives status inserted positive. A current sign of 11 (negative) gives inserted negative in bipolar mode and bypass in unipolar mode.
- R7: During dead-time, a current sign of 00 or 10 gives status free-wheeling.
- R8: Outside dead-time, a submodule's status equals its accepted command.
- R9: In the same cycle as the statuses, `ins_level` equals the number of inserted-positive submodules minus the number of inserted-negative ones, and `free_count` equals the number of free-wheeling submodules.
- R10: In bipolar mode, a direct change from insert positive to insert negative is a single change and opens a single dead-time window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bip_mode | input | 1 | 1 selects bipolar submodules, 0 selects unipolar |
| cur_sign | input | 2 | Arm current direction: 01 positive, 11 negative, 00 or 10 zero |
| dead_cycles | input | TW | Dead-time length in clock cycles, 0 disables |
| min_cycles | input | TW | Minimum command width in clock cycles |
| cmd_in | input | 2*N_SM | Per-submodule command codes, two bits each |
| sm_status | output | 2*N_SM | Per-submodule status codes, two bits each |
| sm_in_dead | output | N_SM | One bit per submodule, set during dead-time |
| ins_level | output | CW+1 | Signed net inserted level |
| free_count | output | CW | Number of free-wheeling submodules |

## Verification
The width filter and the dead-time timer can act on the same submodule in the same cycle. A change that has just passed the minimum-width count can land while an earlier dead-time window is still open, and it must then reload the window. The bench provokes this with short pulses whose length lies just above `min_cycles` and just below `dead_cycles`. It also runs a random phase with small, changing limits. A scoreboard model, written from the requirements, compares every status, every dead-time flag and both arm counts on every cycle, using the current sign that is live at the sample point.

// File: rtl/sg_pkg.sv
package sg_pkg;

    typedef enum logic [1:0] {
        ST_BYP  = 2'b00,
        ST_POS  = 2'b01,
        ST_NEG  = 2'b10,
        ST_FREE = 2'b11
    } sm_state_e;

    // Command code to wanted state; negative insertion exists only in bipolar mode.
    function automatic sm_state_e decode_cmd(input logic [1:0] code, input logic bip);
        sm_state_e r;
        case (code)
            2'b01:   r = ST_POS;
            2'b11:   r = bip ? ST_NEG : ST_BYP;
            default: r = ST_BYP;
        endcase
        return r;
    endfunction

    // State while all switches are off: the diodes steer by current direction.
    function automatic sm_state_e diode_route(input logic [1:0] sign, input logic bip);
        sm_state_e r;
        case (sign)
            2'b01:   r = ST_POS;
            2'b11:   r = bip ? ST_NEG : ST_BYP;
            default: r = ST_FREE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sg_width_filter.sv
module sg_width_filter
    import sg_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bip_mode,
    input  logic [1:0]      cmd_code,
    input  logic [TW-1:0]   min_cycles,
    output sm_state_e       acc,
    output logic            take
);
    localparam logic [TW-1:0] HOLD_MAX = '1;

    sm_state_e     want;
    sm_state_e     prev_q;
    sm_state_e     acc_q;
    logic [TW-1:0] hold_q;
    logic [TW-1:0] hold_n;

    always_comb begin
        want = decode_cmd(cmd_code, bip_mode);
        if (want == prev_q) begin
            hold_n = (hold_q == HOLD_MAX) ? hold_q : hold_q + TW'(1);
        end else begin
            hold_n = TW'(1);
        end
        take = (want != acc_q) && (hold_n >= min_cycles);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= ST_BYP;
            prev_q <= ST_BYP;
            hold_q <= '0;
        end else begin
            prev_q <= want;
            hold_q <= hold_n;
            if (take) begin
                acc_q <= want;
            end
        end
    end

    assign acc = acc_q;

    // R3
    acc_src_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_q != $past(acc_q)) |-> (acc_q == $past(want)));

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((acc_q != $past(acc_q)) && ($past(min_cycles) >= TW'(2)))
        |-> ($past(want, 2) == $past(want)));

endmodule

// File: rtl/sg_dead_timer.sv
module sg_dead_timer
    import sg_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bip_mode,
    input  logic [1:0]      cur_sign,
    input  sm_state_e       acc,
    input  logic            take,
    input  logic [TW-1:0]   dead_cycles,
    output sm_state_e       status,
    output logic            in_dead
);
    logic [TW-1:0] dt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dt_q <= '0;
        end else if (take) begin
            dt_q <= dead_cycles;
        end else if (dt_q != '0) begin
            dt_q <= dt_q - TW'(1);
        end
    end

    always_comb begin
        in_dead = (dt_q != '0);
        status  = in_dead ? diode_route(cur_sign, bip_mode) : acc;
    end

    // R4
    dead_load_chk: assert property (@(posedge clk) disable iff (rst)
        ((acc != $past(acc)) && ($past(dead_cycles) != '0)) |-> in_dead);

    // R4
    dead_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_dead) |-> (acc != $past(acc)));

endmodule

// File: rtl/sg_level_tally.sv
module sg_level_tally
    import sg_pkg::*;
#(
    parameter int N_SM = 8,
    parameter int CW   = $clog2(N_SM + 1)
) (
    input  sm_state_e           st [N_SM],
    output logic signed [CW:0]  ins_level,
    output logic [CW-1:0]       free_count
);
    localparam int LW = CW + 1;

    always_comb begin
        int pos_n;
        int neg_n;
        int fw_n;
        pos_n = 0;
        neg_n = 0;
        fw_n  = 0;
        for (int i = 0; i < N_SM; i++) begin
            if (st[i] == ST_POS)  pos_n = pos_n + 1;
            if (st[i] == ST_NEG)  neg_n = neg_n + 1;
            if (st[i] == ST_FREE) fw_n  = fw_n + 1;
        end
        ins_level  = LW'(pos_n - neg_n);
        free_count = CW'(fw_n);
    end

endmodule

// File: rtl/sm_gate_guard.sv
module sm_gate_guard
    import sg_pkg::*;
#(
    parameter int N_SM = 8,
    parameter int TW   = 8,
    localparam int CW  = $clog2(N_SM + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bip_mode,
    input  logic [1:0]          cur_sign,
    input  logic [TW-1:0]       dead_cycles,
    input  logic [TW-1:0]       min_cycles,
    input  logic [2*N_SM-1:0]   cmd_in,
    output logic [2*N_SM-1:0]   sm_status,
    output logic [N_SM-1:0]     sm_in_dead,
    output logic signed [CW:0]  ins_level,
    output logic [CW-1:0]       free_count
);
    sm_state_e       acc_w [N_SM];
    sm_state_e       st_w  [N_SM];
    logic [N_SM-1:0] take_w;

    for (genvar g = 0; g < N_SM; g++) begin : g_sm
        sg_width_filter #(.TW(TW)) u_filt (
            .clk        (clk),
            .rst        (rst),
            .bip_mode   (bip_mode),
            .cmd_code   (cmd_in[2*g +: 2]),
            .min_cycles (min_cycles),
            .acc        (acc_w[g]),
            .take       (take_w[g])
        );

        sg_dead_timer #(.TW(TW)) u_dead (
            .clk         (clk),
            .rst         (rst),
            .bip_mode    (bip_mode),
            .cur_sign    (cur_sign),
            .acc         (acc_w[g]),
            .take        (take_w[g]),
            .dead_cycles (dead_cycles),
            .status      (st_w[g]),
            .in_dead     (sm_in_dead[g])
        );

        assign sm_status[2*g +: 2] = st_w[g];
    end

    sg_level_tally #(.N_SM(N_SM), .CW(CW)) u_tally (
        .st         (st_w),
        .ins_level  (ins_level),
        .free_count (free_count)
    );

    // R7
    free_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_sign[0] == 1'b0) |-> (free_count == CW'($countones(sm_in_dead))));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> ((sm_in_dead == '0) && (free_count == '0)));

endmodule

// File: tb/sm_gate_guard_test.sv
`timescale 1ns/1ps
module sm_gate_guard_test;
    localparam int N  = 8;
    localparam int TW = 8;
    localparam int CW = $clog2(N + 1);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bip_mode = 1'b1;
    logic [1:0]         cur_sign = 2'b00;
    logic [TW-1:0]      dead_cycles = '0;
    logic [TW-1:0]      min_cycles = '0;
    logic [2*N-1:0]     cmd_in = '0;
    logic [2*N-1:0]     sm_status;
    logic [N-1:0]       sm_in_dead;
    logic signed [CW:0] ins_level;
    logic [CW-1:0]      free_count;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sm_gate_guard #(.N_SM(N), .TW(TW)) uut (
        .clk(clk), .rst(rst), .bip_mode(bip_mode), .cur_sign(cur_sign),
        .dead_cycles(dead_cycles), .min_cycles(min_cycles), .cmd_in(cmd_in),
        .sm_status(sm_status), .sm_in_dead(sm_in_dead),
        .ins_level(ins_level), .free_count(free_count)
    );

    typedef struct {
        logic [2*N-1:0] acc;
        logic [N-1:0]   dd;
        string          tag;
    } item_t;
    item_t sb_q[$];

    // bench-side model state, built from the requirements
    int m_acc [N];
    int m_prev[N];
    int m_hold[N];
    int m_dt  [N];

    function automatic int want_of(input logic [1:0] c, input logic b);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return b ? 2 : 0;
        return 0;
    endfunction

    function automatic int diode_of(input logic [1:0] s, input logic b);
        if (s == 2'b01) return 1;
        if (s == 2'b11) return b ? 2 : 0;
        return 3;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: DUT samples held inputs, model advances, expectation is queued
    task automatic tick(input string tag);
        item_t it;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                m_acc[i] = 0; m_prev[i] = 0; m_hold[i] = 0; m_dt[i] = 0;
            end else begin
                int w;
                int h;
                w = want_of(cmd_in[2*i +: 2], bip_mode);
                h = (w == m_prev[i]) ? ((m_hold[i] < 255) ? m_hold[i] + 1 : 255) : 1;
                m_prev[i] = w;
                m_hold[i] = h;
                if (w != m_acc[i] && h >= int'(min_cycles)) begin
                    m_acc[i] = w;
                    m_dt[i]  = int'(dead_cycles);
                end else if (m_dt[i] > 0) begin
                    m_dt[i] = m_dt[i] - 1;
                end
            end
            it.acc[2*i +: 2] = 2'(m_acc[i]);
            it.dd[i] = (m_dt[i] > 0);
        end
        it.tag = tag;
        sb_q.push_back(it);
        #1;
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) tick(tag);
    endtask

    task automatic set_cmd(input int sm, input logic [1:0] code);
        cmd_in[2*sm +: 2] = code;
    endtask

    // monitor: pops and compares away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [2*N-1:0] est;
            int lvl;
            int fr;
            it = sb_q.pop_front();
            lvl = 0;
            fr = 0;
            for (int i = 0; i < N; i++) begin
                int s;
                s = it.dd[i] ? diode_of(cur_sign, bip_mode) : int'(it.acc[2*i +: 2]);
                est[2*i +: 2] = 2'(s);
                if (s == 1) lvl++;
                if (s == 2) lvl--;
                if (s == 3) fr++;
            end
            check({it.tag, " status"}, int'(sm_status), int'(est));
            check({it.tag, " dead flags"}, int'(sm_in_dead), int'(it.dd));
            check("R9 ins_level", int'(ins_level), lvl);
            check("R9 free_count", int'(free_count), fr);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        run(3, "R1");
        rst = 1'b0;
        run(2, "R1");

        // R2 / R8: direct follow, no protections
        set_cmd(0, 2'b01); set_cmd(1, 2'b11); set_cmd(2, 2'b10);
        run(3, "R2");
        bip_mode = 1'b0;
        run(3, "R2 unipolar");
        bip_mode = 1'b1;
        cmd_in = '0;
        run(3, "R8");

        // R3: minimum width of 4
        min_cycles = 8'd4;
        set_cmd(0, 2'b01);
        run(3, "R3 short");
        set_cmd(0, 2'b00);
        run(6, "R3 short");
        @(negedge clk);
        check("R3 short pulse suppressed", int'(sm_status[1:0]), 0);
        set_cmd(0, 2'b01);
        run(4, "R3 exact");
        set_cmd(0, 2'b00);
        run(6, "R3 exact");
        set_cmd(4, 2'b01);
        run(2, "R3 restart");
        set_cmd(4, 2'b11);
        run(6, "R3 restart");
        @(negedge clk);
        check("R3 restarted value accepted", int'(sm_status[9:8]), 2);
        cmd_in = '0;
        run(6, "R3");

        // R4: dead-time with positive current
        min_cycles = 8'd0;
        dead_cycles = 8'd3;
        cur_sign = 2'b01;
        set_cmd(0, 2'b01);
        run(6, "R4");
        set_cmd(0, 2'b00);
        tick("R4");
        @(negedge clk);
        check("R4 dead after toggle", int'(sm_in_dead[0]), 1);
        run(5, "R4");

        // R5: retrigger during dead-time
        dead_cycles = 8'd5;
        set_cmd(1, 2'b01);
        run(2, "R5");
        set_cmd(1, 2'b00);
        run(8, "R5");

        // R6: negative current, bipolar then unipolar
        dead_cycles = 8'd3;
        cur_sign = 2'b11;
        set_cmd(2, 2'b01);
        run(5, "R6 bipolar");
        bip_mode = 1'b0;
        set_cmd(2, 2'b00);
        run(5, "R6 unipolar");
        bip_mode = 1'b1;

        // R7: zero current, several at once
        cur_sign = 2'b00;
        cmd_in = 16'h5555;
        run(5, "R7");
        cur_sign = 2'b10;
        cmd_in = '0;
        run(5, "R7");

        // R10 plus overlap of width filter and dead window
        cur_sign = 2'b01;
        set_cmd(5, 2'b01);
        run(5, "R10");
        set_cmd(5, 2'b11);
        run(6, "R10");
        min_cycles = 8'd2;
        dead_cycles = 8'd4;
        set_cmd(6, 2'b01);
        run(2, "R5 overlap");
        set_cmd(6, 2'b00);
        run(2, "R5 overlap");
        set_cmd(6, 2'b11);
        run(8, "R5 overlap");

        // R9: random mix
        for (int r = 0; r < 400; r++) begin
            if (r % 50 == 0) begin
                min_cycles  = TW'($urandom_range(0, 3));
                dead_cycles = TW'($urandom_range(0, 4));
                bip_mode    = 1'($urandom_range(0, 1));
            end
            if (r % 3 == 0) cmd_in = 2*N'($urandom);
            if (r % 7 == 0) cur_sign = 2'($urandom_range(0, 3));
            tick("R9 random");
        end
        @(negedge clk);
        #1;
        finish_run();
    end
endmodule